// File: doc/BRIEF.md
# BCD to seven-segment decoder with blanking

This block turns a four-bit decimal digit into the drive pattern for one seven-segment display digit. The segment lines are active-low, so a 0 lights a segment. For each valid digit several segments light at once, each digit with its own set. Three active-low controls sit on top of the lookup. A lamp test lights every segment so that a dead segment can be seen. A blanking input forces the digit dark. A ripple-blanking input and output pair lets a row of decoders hide unwanted zeros.

The blanking input and the ripple-blanking output are separate ports; there is no shared bidirectional pin. In a multi-digit display, the most significant decoder has its ripple-blanking input tied low. Each decoder's ripple-blanking output drives the ripple-blanking input of the next less significant decoder. A zero then goes dark only while every digit to its left is also a dark zero. The block is purely combinational.

Top module: `seg7_blank_decoder`

## Requirements
- R1: With all controls high, codes 0 to 9 drive the standard glyphs. The output bit for segment a is bit 0 and the bit for segment g is bit 6, and a 0 bit means the segment is lit. The lit segments are: 0 = a b c d e f; 1 = b c; 2 = a b d e g; 3 = a b c d g; 4 = b c f g; 5 = a c d f g; 6 = a c d e f g; 7 = a b c; 8 = all seven; 9 = a b c d f g.
- R2: Codes 10 to 15 with all controls high drive every segment off (7'b1111111).
- R3: When lamp test is low and the blanking input is high, every segment is on (7'b0000000). This holds for any code and any ripple-blanking input.
- R4: When the blanking input is low, every segment is off, even with lamp test low.
- R5: The ripple-blanking output is low exactly when the ripple-blanking input is low, lamp test is high and the code is 0. In that case every segment is off.
- R6: With the ripple-blanking input low and lamp test high, a nonzero code still shows its normal R1/R2 pattern, and the ripple-blanking output stays high.
- R7: In a chain of four decoders wired as above, a digit is blanked exactly when it and all more significant digits are zero. Every other digit shows its glyph.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bcd_i | input | 4 | Digit code, bit 3 most significant |
| lt_n_i | input | 1 | Lamp test, active-low |
| rbi_n_i | input | 1 | Ripple-blanking input, active-low |
| bi_n_i | input | 1 | Blanking input, active-low |
| seg_n_o | output | 7 | Segment drives, bit 0 = a ... bit 6 = g, active-low |
| rbo_n_o | output | 1 | Ripple-blanking output, active-low |

## Verification
All sixteen codes are applied with the controls inactive. This separates the ten distinct glyphs from the six dark invalid codes. Directed control combinations then test the priority order. Blanking is set against lamp test, lamp test against ripple blanking, and ripple blanking is tried with a zero and with a nonzero code, which tells zero suppression apart from ordinary blanking. Seeded random vectors over all inputs, and four-digit chain values with zeros in leading, middle and trailing places, show that only leading zeros are suppressed.

// File: rtl/seg7_pkg.sv
package seg7_pkg;

    localparam int SEG_W  = 7;
    localparam int CODE_W = 4;
    localparam int DIGITS = 10;

    typedef enum logic [1:0] {
        MODE_GLYPH = 2'd0,
        MODE_LAMP  = 2'd1,
        MODE_DARK  = 2'd2
    } drive_mode_e;

    // Lit-segment mask, bit 0 = a ... bit 6 = g, 1 = lit
    function automatic logic [SEG_W-1:0] glyph_mask(input logic [CODE_W-1:0] code);
        logic [SEG_W-1:0] m;
        case (code)
            4'd0:    m = 7'b0111111;
            4'd1:    m = 7'b0000110;
            4'd2:    m = 7'b1011011;
            4'd3:    m = 7'b1001111;
            4'd4:    m = 7'b1100110;
            4'd5:    m = 7'b1101101;
            4'd6:    m = 7'b1111101;
            4'd7:    m = 7'b0000111;
            4'd8:    m = 7'b1111111;
            4'd9:    m = 7'b1101111;
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/seg7_glyph_rom.sv
module seg7_glyph_rom
    import seg7_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [SEG_W-1:0]  lit_o,
    output logic              is_zero_o,
    output logic              valid_o
);
    typedef struct packed {
        logic [SEG_W-1:0] lit;
        logic             is_zero;
        logic             valid;
    } rom_out_t;

    rom_out_t rom_d;

    always_comb begin
        rom_d.lit     = glyph_mask(code_i);
        rom_d.is_zero = (code_i == '0);
        rom_d.valid   = (code_i < CODE_W'(DIGITS));
    end

    assign lit_o     = rom_d.lit;
    assign is_zero_o = rom_d.is_zero;
    assign valid_o   = rom_d.valid;

    always_comb begin
        AST_INVALID_UNLIT: assert (rom_d.valid || (rom_d.lit == '0)) else $error("invalid code lit"); // R2
    end
endmodule

// File: rtl/seg7_blank_ctrl.sv
module seg7_blank_ctrl
    import seg7_pkg::*;
(
    input  logic        lt_n_i,
    input  logic        rbi_n_i,
    input  logic        bi_n_i,
    input  logic        is_zero_i,
    output drive_mode_e mode_o,
    output logic        rbo_n_o
);
    typedef struct packed {
        drive_mode_e mode;
        logic        rbo_n;
    } ctl_t;

    ctl_t ctl_d;

    always_comb begin
        ctl_d.rbo_n = !(!rbi_n_i && lt_n_i && is_zero_i);
        if (!bi_n_i)
            ctl_d.mode = MODE_DARK;
        else if (!lt_n_i)
            ctl_d.mode = MODE_LAMP;
        else if (!ctl_d.rbo_n)
            ctl_d.mode = MODE_DARK;
        else
            ctl_d.mode = MODE_GLYPH;
    end

    assign mode_o  = ctl_d.mode;
    assign rbo_n_o = ctl_d.rbo_n;
endmodule

// File: rtl/seg7_out_drive.sv
module seg7_out_drive
    import seg7_pkg::*;
(
    input  drive_mode_e      mode_i,
    input  logic [SEG_W-1:0] lit_i,
    output logic [SEG_W-1:0] seg_n_o
);
    for (genvar s = 0; s < SEG_W; s++) begin : g_seg
        always_comb begin
            case (mode_i)
                MODE_DARK:  seg_n_o[s] = 1'b1;
                MODE_LAMP:  seg_n_o[s] = 1'b0;
                default:    seg_n_o[s] = ~lit_i[s];
            endcase
        end
    end
endmodule

// File: rtl/seg7_blank_decoder.sv
module seg7_blank_decoder
    import seg7_pkg::*;
(
    input  logic [3:0] bcd_i,
    input  logic       lt_n_i,
    input  logic       rbi_n_i,
    input  logic       bi_n_i,
    output logic [6:0] seg_n_o,
    output logic       rbo_n_o
);
    logic [SEG_W-1:0] lit_d;
    logic             is_zero_d;
    logic             valid_d;
    drive_mode_e      mode_d;

    seg7_glyph_rom i_rom (
        .code_i    (bcd_i),
        .lit_o     (lit_d),
        .is_zero_o (is_zero_d),
        .valid_o   (valid_d)
    );

    seg7_blank_ctrl i_ctl (
        .lt_n_i    (lt_n_i),
        .rbi_n_i   (rbi_n_i),
        .bi_n_i    (bi_n_i),
        .is_zero_i (is_zero_d),
        .mode_o    (mode_d),
        .rbo_n_o   (rbo_n_o)
    );

    seg7_out_drive i_drv (
        .mode_i  (mode_d),
        .lit_i   (lit_d),
        .seg_n_o (seg_n_o)
    );

    always_comb begin
        AST_BLANK_DARK: assert (bi_n_i || (seg_n_o == '1)) else $error("blank not dark"); // R4
        AST_LAMP_ALL_ON: assert (!(bi_n_i && !lt_n_i) || (seg_n_o == '0)) else $error("lamp test not lit"); // R3
        AST_RBO_ZERO_DARK: assert (rbo_n_o || (is_zero_d && (seg_n_o == '1))) else $error("ripple blank wrong"); // R5
        AST_GLYPH_MULTI: assert (!(valid_d && bi_n_i && lt_n_i && rbo_n_o) || ($countones(~seg_n_o) >= 2)) else $error("glyph too few segments"); // R1
        AST_INVALID_DARK: assert (valid_d || !(bi_n_i && lt_n_i) || (seg_n_o == '1)) else $error("invalid code lit"); // R2
    end
endmodule

// File: tb/test_seg7_blank_decoder.sv
module test_seg7_blank_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 20000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [3:0] bcd;
    logic lt_n, rbi_n, bi_n;
    logic [6:0] seg_n;
    logic rbo_n;

    seg7_blank_decoder i_seg7_blank_decoder (
        .bcd_i(bcd), .lt_n_i(lt_n), .rbi_n_i(rbi_n), .bi_n_i(bi_n),
        .seg_n_o(seg_n), .rbo_n_o(rbo_n)
    );

    // chain: index 3 is most significant
    logic [3:0] cb [4];
    logic [6:0] cseg [4];
    logic [4:0] crip;
    assign crip[4] = 1'b0;
    for (genvar k = 0; k < 4; k++) begin : g_chain
        seg7_blank_decoder i_chain (
            .bcd_i(cb[k]), .lt_n_i(1'b1), .rbi_n_i(crip[k+1]), .bi_n_i(1'b1),
            .seg_n_o(cseg[k]), .rbo_n_o(crip[k])
        );
    end

    function automatic logic [6:0] lit_of(input logic [3:0] c);
        logic [6:0] t [10];
        t = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
        return (c < 10) ? t[c] : 7'h00;
    endfunction

    function automatic logic exp_rbo(input logic [3:0] c, input logic lt, input logic rbi);
        return !(!rbi && lt && c == 0);
    endfunction

    function automatic logic [6:0] exp_seg(input logic [3:0] c, input logic lt, input logic rbi, input logic bi);
        if (!bi) return 7'h7F;
        if (!lt) return 7'h00;
        if (!exp_rbo(c, lt, rbi)) return 7'h7F;
        return ~lit_of(c);
    endfunction

    task automatic check(input string req, input logic [3:0] c, input logic lt, input logic rbi, input logic bi);
        logic [6:0] es;
        logic er;
        bcd = c; lt_n = lt; rbi_n = rbi; bi_n = bi;
        @(negedge clk);
        es = exp_seg(c, lt, rbi, bi);
        er = exp_rbo(c, lt, rbi);
        n_checks++;
        if (seg_n !== es || rbo_n !== er) begin
            n_fail++;
            $display("FAIL %s code=%0d lt=%b rbi=%b bi=%b: seg=%b rbo=%b expected seg=%b rbo=%b",
                     req, c, lt, rbi, bi, seg_n, rbo_n, es, er);
        end
        @(posedge clk);
    endtask

    task automatic check_chain(input logic [15:0] v);
        logic lead;
        logic [6:0] es;
        for (int k = 0; k < 4; k++) cb[k] = v[4*k +: 4];
        @(negedge clk);
        lead = 1'b1;
        for (int k = 3; k >= 0; k--) begin
            lead = lead && (v[4*k +: 4] == 4'd0);
            es = lead ? 7'h7F : ~lit_of(v[4*k +: 4]);
            n_checks++;
            if (cseg[k] !== es) begin
                n_fail++;
                $display("FAIL R7 value=%h digit=%0d: seg=%b expected %b", v, k, cseg[k], es);
            end
        end
        @(posedge clk);
    endtask

    initial begin
        int unsigned r;
        logic [15:0] chain_cases [6];
        bcd = 0; lt_n = 1; rbi_n = 1; bi_n = 1;
        for (int k = 0; k < 4; k++) cb[k] = 0;
        void'($urandom(32'd20240611));
        @(posedge clk);
        // idle state: code 0, controls inactive shows glyph 0
        check("R1", 4'd0, 1'b1, 1'b1, 1'b1);
        for (int c = 0; c < 10; c++) check("R1", 4'(c), 1'b1, 1'b1, 1'b1);
        for (int c = 10; c < 16; c++) check("R2", 4'(c), 1'b1, 1'b1, 1'b1);
        check("R3", 4'd0,  1'b0, 1'b0, 1'b1);
        check("R3", 4'd13, 1'b0, 1'b1, 1'b1);
        check("R3", 4'd7,  1'b0, 1'b0, 1'b1);
        check("R4", 4'd8,  1'b0, 1'b1, 1'b0);
        check("R4", 4'd5,  1'b1, 1'b1, 1'b0);
        check("R4", 4'd0,  1'b0, 1'b0, 1'b0);
        check("R5", 4'd0,  1'b1, 1'b0, 1'b1);
        check("R5", 4'd0,  1'b1, 1'b0, 1'b0);
        check("R6", 4'd1,  1'b1, 1'b0, 1'b1);
        check("R6", 4'd9,  1'b1, 1'b0, 1'b1);
        check("R6", 4'd11, 1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 300; i++) begin
            r = $urandom;
            check("R1..R6 random", r[3:0], r[4], r[5], (r[8:6] != 0));
        end
        chain_cases = '{16'h0000, 16'h0007, 16'h0105, 16'h1000, 16'h0020, 16'h9090};
        for (int i = 0; i < 6; i++) check_chain(chain_cases[i]);
        for (int i = 0; i < 100; i++) begin
            r = $urandom;
            // bias digits toward zero and keep them valid
            check_chain({(r[3] ? 4'(r[2:0]) : 4'd0), (r[7] ? 4'(r[6:4]) : 4'd0),
                         (r[11] ? 4'(r[10:8]) : 4'd0), (r[15] ? 4'(r[14:12]) : 4'd0)});
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule